// File: doc/BRIEF.md
# Congestion-Aware Multipath Flow Selector

This block is the transmit-side path chooser for a single connection that is spread over several network flows. Each flow carries its own path label in outgoing packets, and each flow keeps two windows and a count of packets still unacknowledged. One window is set by the fabric congestion controller and the other by the receiver host/NIC congestion controller. Whenever a packet is waiting, the block offers the flow with the most room left, together with that flow's path label. A handshake moves the packet onto that flow.

Software programs both windows and the label of every flow through a simple write port. The hardware only enforces the windows and makes the choice. Acknowledgements give room back to the flow they name. The block makes one decision per cycle. The decision is a combinational function of the registered per-flow state, so a write, a transmit or an acknowledgement affects the choice from the next cycle on.

Top module: `multipath_flow_picker`

## Requirements
- R1: During and directly after reset all windows, labels and in-flight counts are zero, so `pkt_ready` is low.
- R2: A write with `cfg_we` high stores `cfg_data` into flow `cfg_idx`. Field code 0 selects the fabric window, code 1 the host window and code 2 the path label. The new value governs the choice from the next cycle.
- R3: A flow's usable window is the smaller of its fabric and host windows. Its room is the usable window minus its in-flight count, or zero when the count is not below the usable window.
- R4: `sel_idx` names the flow with the largest room. When several flows share that largest room, the lowest index among them wins.
- R5: When no flow has room above zero, `pkt_ready` is low, and a request made with `pkt_valid` changes no in-flight count.
- R6: When `pkt_valid` and `pkt_ready` are both high, the in-flight count of the flow named by `sel_idx` rises by one at the next clock edge.
- R7: An acknowledgement (`ack_valid`) lowers the in-flight count of flow `ack_idx` by `ack_cnt`. The count stops at zero.
- R8: When a transmit and an acknowledgement hit the same flow in one cycle, the acknowledgement is applied first, including its floor at zero, and the transmit then adds one.
- R9: While `pkt_ready` is high, `sel_label` is the stored path label of the flow named by `sel_idx`.
- R10: A write with field code 3 changes no window and no label.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_field | input | 2 | 0 fabric window, 1 host window, 2 path label, 3 no effect |
| cfg_idx | input | IDXW (2) | Flow addressed by the write |
| cfg_data | input | CFGW (20) | Value written |
| pkt_valid | input | 1 | A packet is waiting to be sent |
| pkt_ready | output | 1 | Some flow has room; the packet may go |
| sel_idx | output | IDXW (2) | Chosen flow |
| sel_label | output | LBLW (20) | Path label of the chosen flow |
| ack_valid | input | 1 | Acknowledgement strobe |
| ack_idx | input | IDXW (2) | Flow being acknowledged |
| ack_cnt | input | WINW (16) | Number of packets acknowledged |

## Verification
The assertions assume that `cfg_idx` and `ack_idx` always name an existing flow. They also assume that software keeps a window of at most the largest in-flight count the counter can hold, so that an increment after a grant cannot wrap. The stimulus uses only 8-bit window values and the four implemented flow indices. Every transmit request and acknowledgement comes from the bench's own sequence, and each one is made against a state the bench has already checked.

// File: rtl/multipath_flow_picker.sv
module multipath_flow_picker #(
  parameter int NFLOWS = 4,
  parameter int WINW   = 16,
  parameter int LBLW   = 20,
  parameter int IDXW   = (NFLOWS > 1) ? $clog2(NFLOWS) : 1,
  parameter int CFGW   = (WINW > LBLW) ? WINW : LBLW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [1:0]      cfg_field,
  input  logic [IDXW-1:0] cfg_idx,
  input  logic [CFGW-1:0] cfg_data,
  input  logic            pkt_valid,
  output logic            pkt_ready,
  output logic [IDXW-1:0] sel_idx,
  output logic [LBLW-1:0] sel_label,
  input  logic            ack_valid,
  input  logic [IDXW-1:0] ack_idx,
  input  logic [WINW-1:0] ack_cnt
);

  logic [WINW-1:0] fab_q   [NFLOWS];
  logic [WINW-1:0] host_q  [NFLOWS];
  logic [WINW-1:0] infl_q  [NFLOWS];
  logic [LBLW-1:0] lbl_q   [NFLOWS];
  logic [WINW-1:0] eff_w   [NFLOWS];
  logic [WINW-1:0] avail_w [NFLOWS];
  logic [WINW-1:0] infl_nx [NFLOWS];
  logic [IDXW-1:0] best_idx;
  logic [WINW-1:0] best_av;

  wire tx_fire = pkt_valid & pkt_ready;

  always_comb begin
    best_idx = '0;
    best_av  = '0;
    for (int i = 0; i < NFLOWS; i++) begin
      eff_w[i]   = (fab_q[i] < host_q[i]) ? fab_q[i] : host_q[i];
      avail_w[i] = (eff_w[i] > infl_q[i]) ? eff_w[i] - infl_q[i] : '0;
      if (avail_w[i] > best_av) begin
        best_av  = avail_w[i];
        best_idx = IDXW'(i);
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NFLOWS; i++) begin
      infl_nx[i] = infl_q[i];
      if (ack_valid && ack_idx == IDXW'(i))
        infl_nx[i] = (ack_cnt >= infl_q[i]) ? '0 : infl_q[i] - ack_cnt;
      if (tx_fire && best_idx == IDXW'(i))
        infl_nx[i] = infl_nx[i] + WINW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NFLOWS; i++) begin
        fab_q[i]  <= '0;
        host_q[i] <= '0;
        infl_q[i] <= '0;
        lbl_q[i]  <= '0;
      end
    end else begin
      for (int i = 0; i < NFLOWS; i++) begin
        infl_q[i] <= infl_nx[i];
        if (cfg_we && cfg_idx == IDXW'(i)) begin
          case (cfg_field)
            2'd0:    fab_q[i]  <= cfg_data[WINW-1:0];
            2'd1:    host_q[i] <= cfg_data[WINW-1:0];
            2'd2:    lbl_q[i]  <= cfg_data[LBLW-1:0];
            default: ;
          endcase
        end
      end
    end
  end

  assign pkt_ready = (best_av != '0);
  assign sel_idx   = best_idx;
  assign sel_label = lbl_q[best_idx];

  for (genvar j = 0; j < NFLOWS; j++) begin : g_chk
    p_pick_is_max_r4: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_ready |-> avail_w[sel_idx] >= avail_w[j]);

    if (j > 0) begin : g_tie
      p_tie_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_ready && sel_idx > IDXW'(j - 1)) |-> avail_w[j-1] < avail_w[sel_idx]);
    end

    p_no_room_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !pkt_ready |-> avail_w[j] == '0);

    p_tx_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_fire && sel_idx == IDXW'(j) && !(ack_valid && ack_idx == IDXW'(j)))
      |=> infl_q[j] == $past(infl_q[j]) + WINW'(1));

    p_ack_floor_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_valid && ack_idx == IDXW'(j) && ack_cnt >= infl_q[j] &&
       !(tx_fire && sel_idx == IDXW'(j))) |=> infl_q[j] == '0);

    p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!pkt_ready && !ack_valid) |=> $stable(infl_q[j]));
  end

endmodule

// File: tb/multipath_flow_picker_bench.sv
module multipath_flow_picker_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [1:0]  cfg_field;
  logic [1:0]  cfg_idx;
  logic [19:0] cfg_data;
  logic        pkt_valid;
  logic        pkt_ready;
  logic [1:0]  sel_idx;
  logic [19:0] sel_label;
  logic        ack_valid;
  logic [1:0]  ack_idx;
  logic [15:0] ack_cnt;

  int nchk  = 0;
  int nfail = 0;

  always #2 clk = ~clk;

  multipath_flow_picker u_multipath_flow_picker (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_field(cfg_field), .cfg_idx(cfg_idx), .cfg_data(cfg_data),
    .pkt_valid(pkt_valid), .pkt_ready(pkt_ready),
    .sel_idx(sel_idx), .sel_label(sel_label),
    .ack_valid(ack_valid), .ack_idx(ack_idx), .ack_cnt(ack_cnt)
  );

  // one byte per flow, flow 0 in the low byte; expectation is {ready, idx}
  localparam int NV = 6;
  localparam logic [31:0] FABV  [NV] = '{32'h02080305, 32'h09090909, 32'h00000000,
                                          32'h06060606, 32'h03000001, 32'h32FF64C8};
  localparam logic [31:0] HOSTV [NV] = '{32'h0A0A0A0A, 32'h01070704, 32'h05050505,
                                          32'h06060606, 32'h05050500, 32'h3C78FA96};
  localparam logic [2:0]  EXPV  [NV] = '{3'b110, 3'b101, 3'b000,
                                          3'b100, 3'b111, 3'b100};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cfg(input logic [1:0] fld, input logic [1:0] idx, input logic [19:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_field = fld; cfg_idx = idx; cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic step(input logic tx, input logic ack, input logic [1:0] aidx,
                      input logic [15:0] acnt);
    @(negedge clk);
    pkt_valid = tx; ack_valid = ack; ack_idx = aidx; ack_cnt = acnt;
    @(negedge clk);
    pkt_valid = 1'b0; ack_valid = 1'b0;
  endtask

  task automatic expect_pick(input string req, input logic rdy, input logic [1:0] idx);
    chk(req, {31'd0, pkt_ready}, {31'd0, rdy});
    if (rdy) chk(req, {30'd0, sel_idx}, {30'd0, idx});
  endtask

  initial begin
    #(4 * 150000);
    nfail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_field = '0; cfg_idx = '0; cfg_data = '0;
    pkt_valid = 1'b0; ack_valid = 1'b0; ack_idx = '0; ack_cnt = '0;
    repeat (3) @(negedge clk);
    chk("R1 ready in reset", {31'd0, pkt_ready}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready after reset", {31'd0, pkt_ready}, 32'd0);
    chk("R1 label after reset", {12'd0, sel_label}, 32'd0);

    for (int f = 0; f < 4; f++) cfg(2'd2, 2'(f), 20'hA5000 + 20'(f));

    // table walk: R2 writes, R3 min and floor, R4 max with low-index tie, R9 label
    for (int v = 0; v < NV; v++) begin
      for (int f = 0; f < 4; f++) begin
        cfg(2'd0, 2'(f), {12'd0, FABV[v][8*f +: 8]});
        cfg(2'd1, 2'(f), {12'd0, HOSTV[v][8*f +: 8]});
      end
      expect_pick($sformatf("R4 vector %0d", v), EXPV[v][2], EXPV[v][1:0]);
      if (EXPV[v][2])
        chk($sformatf("R9 vector %0d", v), {12'd0, sel_label},
            {12'd0, 20'hA5000 + {18'd0, EXPV[v][1:0]}});
    end

    // R10: code 3 on flow 1 must not raise its room above flow 0's 150
    cfg(2'd3, 2'd1, 20'h000FF);
    expect_pick("R10 ignored field", 1'b1, 2'd0);
    chk("R10 label kept", {12'd0, sel_label}, {12'd0, 20'hA5000});

    // sequence: fabric 3,2,0,0 ; host 10 everywhere
    cfg(2'd0, 2'd0, 20'd3); cfg(2'd0, 2'd1, 20'd2);
    cfg(2'd0, 2'd2, 20'd0); cfg(2'd0, 2'd3, 20'd0);
    for (int f = 0; f < 4; f++) cfg(2'd1, 2'(f), 20'd10);
    expect_pick("R2 new windows", 1'b1, 2'd0);
    step(1'b1, 1'b0, 2'd0, 16'd0);               // f0 1 -> room 2,2
    expect_pick("R6 first send tie", 1'b1, 2'd0);
    step(1'b1, 1'b0, 2'd0, 16'd0);               // f0 2 -> room 1,2
    expect_pick("R6 second send", 1'b1, 2'd1);
    step(1'b1, 1'b0, 2'd0, 16'd0);               // f1 1 -> room 1,1
    expect_pick("R6 third send", 1'b1, 2'd0);
    step(1'b1, 1'b0, 2'd0, 16'd0);               // f0 3 -> room 0,1
    expect_pick("R6 fourth send", 1'b1, 2'd1);
    step(1'b1, 1'b0, 2'd0, 16'd0);               // f1 2 -> room 0,0
    expect_pick("R5 exhausted", 1'b0, 2'd0);
    step(1'b1, 1'b0, 2'd0, 16'd0);               // refused request
    expect_pick("R5 stall keeps counts", 1'b0, 2'd0);
    step(1'b0, 1'b1, 2'd1, 16'd1);               // f1 1 -> room 0,1
    expect_pick("R5 refused request no count", 1'b1, 2'd1);
    step(1'b0, 1'b1, 2'd0, 16'd5);               // f0 floors at 0 -> room 3,1
    expect_pick("R7 ack saturates", 1'b1, 2'd0);
    step(1'b1, 1'b1, 2'd0, 16'd2);               // f0 = max(0-2,0)+1 = 1
    cfg(2'd0, 2'd0, 20'd1);                      // f0 room 0 when count is 1
    expect_pick("R8 ack then send", 1'b1, 2'd1);
    cfg(2'd1, 2'd1, 20'd0);                      // f1 usable 0 under count 1
    expect_pick("R3 floor at zero", 1'b0, 2'd0);
    cfg(2'd1, 2'd1, 20'd4);                      // f1 room min(2,4)-1 = 1
    expect_pick("R3 min of windows", 1'b1, 2'd1);
    chk("R9 label flow1", {12'd0, sel_label}, {12'd0, 20'hA5001});

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule